// File: doc/BRIEF.md
# Interrupt wakeup and power-mode controller

This block sits beside a CPU core and owns two interrupt pins: a configurable external interrupt and a nonmaskable interrupt. It turns pin activity into pending flags and one prioritized request to the core. It also tracks the run, idle and powerdown modes, and on a wake it tells the core how to resume. The external interrupt can be edge-triggered or level-sampled. A sense bit chooses whether a rising edge or high level is active, or a falling edge or low level. The nonmaskable pin is rising-edge only and is filtered, so that a pulse narrower than a set number of clock samples is dropped.

The core enters a low-power mode by issuing a command. In idle the clock keeps running, and any enabled pending source ends the mode. In powerdown the clock is assumed stopped. An asynchronous latch captures an active level on the external pin whether or not that interrupt is enabled. The latch is then resynchronized once the clock is back. Every wake returns the block to run and emits a one-cycle resume strobe. A flag on the strobe tells the core either to take the interrupt vector or to carry on at the instruction after the one that started the low-power mode.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: After reset the mode is run (code 0), both pending flags are 0, irq_req is 0 and resume_pulse is 0. The configuration resets to edge-triggered, rising sense.
- R2: The configuration write data has bit 0 as the mode bit (0 edge, 1 level) and bit 1 as the sense bit (1 rising/high, 0 falling/low). In edge mode an active edge on ext_pin sets ext_pend after the third rising clock edge following the pin change, with the default two synchronizer stages. ack_ext clears the flag, and a pin held active does not set it again.
- R3: In level mode ext_pend follows the active level of ext_pin with the same three-edge latency, and ack_ext has no effect on it.
- R4: With the sense bit at 0, a falling edge (edge mode) or a low level (level mode) is active, and a rising edge does nothing.
- R5: A configuration write clears ext_pend at the next clock edge. In edge mode a pin that holds its level across a configuration change does not set ext_pend.
- R6: A rising edge on nmi_pin sets nmi_pend only if the synchronized pin is high for at least NMI_MIN consecutive clock samples (default 2). With the default the flag shows after the fourth edge, and a one-cycle pulse is ignored. ack_nmi clears the flag.
- R7: In run mode irq_req is high when nmi_pend is set, or when ext_pend is set and ext_en is high. irq_is_nmi is high whenever nmi_pend takes part, so the nonmaskable source wins over the external one. irq_req is 0 in idle and powerdown.
- R8: mode_cmd codes are 0 run, 1 idle, 2 powerdown. A valid command in run with code 1 or 2 enters that mode at the next edge. Code 3, and any command given outside run, is ignored.
- R9: In idle, a set nmi_pend or an enabled ext_pend returns the mode to run at the next edge with resume_vector 1. A pending external flag with ext_en low does not end idle.
- R10: In powerdown an active level on ext_pin, however short, is latched, and the third following edge returns the mode to run. resume_vector then equals ext_en. When ext_en is high, ext_pend is set at that edge in edge mode. The nonmaskable pin is ignored in powerdown.
- R11: resume_pulse is high for exactly one cycle for each wake, and only on a transition from idle or powerdown to run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 2 | Bit 0 level mode, bit 1 active-high sense |
| ext_pin | input | 1 | External interrupt pin (asynchronous) |
| nmi_pin | input | 1 | Nonmaskable interrupt pin (asynchronous) |
| ext_en | input | 1 | Enable mask for the external interrupt |
| mode_cmd_valid | input | 1 | Mode command strobe |
| mode_cmd | input | 2 | Requested mode: 0 run, 1 idle, 2 powerdown |
| ack_ext | input | 1 | Core acknowledges the external vector |
| ack_nmi | input | 1 | Core acknowledges the nonmaskable vector |
| ext_pend | output | 1 | External interrupt pending |
| nmi_pend | output | 1 | Nonmaskable interrupt pending |
| irq_req | output | 1 | Interrupt request to the core |
| irq_is_nmi | output | 1 | Request is for the nonmaskable vector |
| pm_state | output | 2 | Current mode: 0 run, 1 idle, 2 powerdown |
| resume_pulse | output | 1 | One-cycle wake strobe |
| resume_vector | output | 1 | With resume_pulse: 1 take vector, 0 continue |

## Verification
The external and the nonmaskable interrupt can be pending at once, and the request arbitration must then favour the nonmaskable one. The bench raises both pins on the same clock. The external flag lands one cycle ahead of the nonmaskable one, because of the wider filter. The bench checks irq_is_nmi before and after the nonmaskable flag lands, and checks again once ack_nmi leaves only the external request. A second overlap, a configuration write while the pin holds an active level, is judged by the pending flag staying clear.

// File: rtl/pwr_wake_pkg.sv
package pwr_wake_pkg;

  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_IDLE  = 2'd1,
    PM_PDOWN = 2'd2
  } pm_state_e;

  // Pin level after applying the configured sense.
  function automatic logic sense_active(input logic lvl, input logic act_hi);
    return act_hi ? lvl : ~lvl;
  endfunction

  // A mode command is honoured only from run with a sleep code.
  function automatic logic is_sleep_cmd(input logic [1:0] cmd);
    return (cmd == PM_IDLE) || (cmd == PM_PDOWN);
  endfunction

endpackage

// File: rtl/wake_pin_sync.sv
module wake_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   stg <= '0;
    else if (clr) stg <= '0;
    else          stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/ext_int_detect.sv
module ext_int_detect
  import pwr_wake_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s,
  input  logic level_mode,
  input  logic act_hi,
  input  logic cfg_we,
  input  logic ack,
  input  logic detect_en,
  input  logic force_set,
  output logic edge_ev,
  output logic pend
);
  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= pin_s;
  end

  assign edge_ev = detect_en & sense_active(pin_s, act_hi) & ~sense_active(prev, act_hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 pend <= 1'b0;
    else if (cfg_we)            pend <= 1'b0;
    else if (level_mode)        pend <= detect_en & sense_active(pin_s, act_hi);
    else if (edge_ev | force_set) pend <= 1'b1;
    else if (ack)               pend <= 1'b0;
  end
endmodule

// File: rtl/nmi_filter.sv
module nmi_filter #(
  parameter int NMI_MIN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s,
  input  logic detect_en,
  input  logic ack,
  output logic nmi_ev,
  output logic pend
);
  localparam int CW = $clog2(NMI_MIN + 1);
  logic [CW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     hi_cnt <= '0;
    else if (!pin_s)                hi_cnt <= '0;
    else if (hi_cnt != CW'(NMI_MIN)) hi_cnt <= hi_cnt + CW'(1);
  end

  assign nmi_ev = detect_en & pin_s & (hi_cnt == CW'(NMI_MIN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend <= 1'b0;
    else if (nmi_ev) pend <= 1'b1;
    else if (ack)    pend <= 1'b0;
  end
endmodule

// File: rtl/pd_wake_latch.sv
module pd_wake_latch #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic pin_act,
  output logic wake
);
  logic set_req;
  logic held;

  assign set_req = arm & pin_act;

  // Captures without a clock; cleared once the mode has left powerdown.
  always_ff @(posedge clk or negedge rst_n or posedge set_req) begin
    if (!rst_n)       held <= 1'b0;
    else if (set_req) held <= 1'b1;
    else if (!arm)    held <= 1'b0;
  end

  wake_pin_sync #(.STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .clr(~arm), .d(held), .q(wake)
  );
endmodule

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl
  import pwr_wake_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int NMI_MIN     = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [1:0] cfg_wdata,
  input  logic       ext_pin,
  input  logic       nmi_pin,
  input  logic       ext_en,
  input  logic       mode_cmd_valid,
  input  logic [1:0] mode_cmd,
  input  logic       ack_ext,
  input  logic       ack_nmi,
  output logic       ext_pend,
  output logic       nmi_pend,
  output logic       irq_req,
  output logic       irq_is_nmi,
  output logic [1:0] pm_state,
  output logic       resume_pulse,
  output logic       resume_vector
);
  pm_state_e state;
  logic cfg_level, cfg_act_hi;
  logic ext_s, nmi_s;
  logic ext_edge_ev, nmi_ev;
  logic in_run, in_idle, in_pd;
  logic idle_wake, pd_wake, pd_force;

  assign in_run  = (state == PM_RUN);
  assign in_idle = (state == PM_IDLE);
  assign in_pd   = (state == PM_PDOWN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_level  <= 1'b0;
      cfg_act_hi <= 1'b1;
    end else if (cfg_we) begin
      cfg_level  <= cfg_wdata[0];
      cfg_act_hi <= cfg_wdata[1];
    end
  end

  wake_pin_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk(clk), .rst_n(rst_n), .clr(1'b0), .d(ext_pin), .q(ext_s)
  );
  wake_pin_sync #(.STAGES(SYNC_STAGES)) u_nmi_sync (
    .clk(clk), .rst_n(rst_n), .clr(1'b0), .d(nmi_pin), .q(nmi_s)
  );

  pd_wake_latch #(.STAGES(SYNC_STAGES)) u_pd_latch (
    .clk(clk), .rst_n(rst_n), .arm(in_pd),
    .pin_act(sense_active(ext_pin, cfg_act_hi)), .wake(pd_wake)
  );

  assign pd_force = in_pd & pd_wake & ext_en;

  ext_int_detect u_ext (
    .clk(clk), .rst_n(rst_n), .pin_s(ext_s), .level_mode(cfg_level),
    .act_hi(cfg_act_hi), .cfg_we(cfg_we), .ack(ack_ext), .detect_en(~in_pd),
    .force_set(pd_force), .edge_ev(ext_edge_ev), .pend(ext_pend)
  );

  nmi_filter #(.NMI_MIN(NMI_MIN)) u_nmi (
    .clk(clk), .rst_n(rst_n), .pin_s(nmi_s), .detect_en(~in_pd),
    .ack(ack_nmi), .nmi_ev(nmi_ev), .pend(nmi_pend)
  );

  assign idle_wake = in_idle & (nmi_pend | (ext_pend & ext_en));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= PM_RUN;
      resume_pulse  <= 1'b0;
      resume_vector <= 1'b0;
    end else begin
      resume_pulse  <= 1'b0;
      resume_vector <= 1'b0;
      unique case (state)
        PM_RUN: begin
          if (mode_cmd_valid && is_sleep_cmd(mode_cmd)) state <= pm_state_e'(mode_cmd);
        end
        PM_IDLE: begin
          if (idle_wake) begin
            state         <= PM_RUN;
            resume_pulse  <= 1'b1;
            resume_vector <= 1'b1;
          end
        end
        PM_PDOWN: begin
          if (pd_wake) begin
            state         <= PM_RUN;
            resume_pulse  <= 1'b1;
            resume_vector <= ext_en;
          end
        end
        default: state <= PM_RUN;
      endcase
    end
  end

  assign irq_req    = in_run & (nmi_pend | (ext_pend & ext_en));
  assign irq_is_nmi = in_run & nmi_pend;
  assign pm_state   = state;
endmodule

// File: rtl/pwr_wake_chk.sv
module pwr_wake_chk
  import pwr_wake_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] state,
  input logic       cfg_we,
  input logic       ext_en,
  input logic       ext_pend,
  input logic       nmi_pend,
  input logic       nmi_s,
  input logic       ext_edge_ev,
  input logic       nmi_ev,
  input logic       irq_req,
  input logic       irq_is_nmi,
  input logic       resume_pulse,
  input logic       resume_vector
);
  a_r11_resume_single: assert property (@(posedge clk) disable iff (!rst_n)
    resume_pulse |=> !resume_pulse);

  a_r11_resume_from_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    resume_pulse |-> (state == PM_RUN) && ($past(state) != PM_RUN));

  a_r7_nmi_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PM_RUN && nmi_pend) |-> (irq_req && irq_is_nmi));

  a_r7_quiet_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    (state != PM_RUN) |-> !irq_req);

  a_r5_cfg_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> !ext_pend);

  a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PM_IDLE && !nmi_pend && !(ext_pend && ext_en)) |=> (state == PM_IDLE));

  a_r10_pd_target: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_pulse && $past(state) == PM_PDOWN) |-> (resume_vector == $past(ext_en)));

  a_r6_nmi_needs_level: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_pend) |-> ($past(nmi_s) && $past(nmi_ev)));

  a_r10_no_event_in_pd: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PM_PDOWN) |-> (!nmi_ev && !ext_edge_ev));
endmodule

bind pwr_wake_ctrl pwr_wake_chk u_chk (
  .clk(clk), .rst_n(rst_n), .state(state), .cfg_we(cfg_we), .ext_en(ext_en),
  .ext_pend(ext_pend), .nmi_pend(nmi_pend), .nmi_s(nmi_s),
  .ext_edge_ev(ext_edge_ev), .nmi_ev(nmi_ev), .irq_req(irq_req),
  .irq_is_nmi(irq_is_nmi), .resume_pulse(resume_pulse), .resume_vector(resume_vector)
);

// File: tb/test_pwr_wake_ctrl.sv
module test_pwr_wake_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_wdata = 2'b10;
  logic ext_pin = 1'b0, nmi_pin = 1'b0, ext_en = 1'b0;
  logic mode_cmd_valid = 1'b0;
  logic [1:0] mode_cmd = 2'd0;
  logic ack_ext = 1'b0, ack_nmi = 1'b0;
  logic ext_pend, nmi_pend, irq_req, irq_is_nmi, resume_pulse, resume_vector;
  logic [1:0] pm_state;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_wake_ctrl i_pwr_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .ext_pin(ext_pin), .nmi_pin(nmi_pin), .ext_en(ext_en),
    .mode_cmd_valid(mode_cmd_valid), .mode_cmd(mode_cmd),
    .ack_ext(ack_ext), .ack_nmi(ack_nmi), .ext_pend(ext_pend),
    .nmi_pend(nmi_pend), .irq_req(irq_req), .irq_is_nmi(irq_is_nmi),
    .pm_state(pm_state), .resume_pulse(resume_pulse), .resume_vector(resume_vector)
  );

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cfg(input logic lvl, input logic hi);
    cfg_wdata = {hi, lvl};
    cfg_we = 1'b1;
    tick(1);
    cfg_we = 1'b0;
  endtask

  task automatic send_mode(input logic [1:0] c);
    mode_cmd = c;
    mode_cmd_valid = 1'b1;
    tick(1);
    mode_cmd_valid = 1'b0;
  endtask

  task automatic pulse_ack(input bit is_nmi);
    if (is_nmi) ack_nmi = 1'b1; else ack_ext = 1'b1;
    tick(1);
    ack_nmi = 1'b0;
    ack_ext = 1'b0;
  endtask

  // Scoreboard monitor: every resume strobe is matched to a queued target.
  always @(negedge clk) begin
    if (rst_n && resume_pulse) begin
      if (exp_q.size() == 0) begin
        chk("R11 unexpected resume", 4'(resume_pulse), 4'h0);
      end else begin
        chk("R9/R10 resume target", 4'(resume_vector), 4'(exp_q.pop_front()));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    tick(2);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    chk("R1 mode", 4'(pm_state), 4'h0);
    chk("R1 ext_pend", 4'(ext_pend), 4'h0);
    chk("R1 nmi_pend", 4'(nmi_pend), 4'h0);
    chk("R1 irq_req", 4'(irq_req), 4'h0);
    chk("R1 resume", 4'(resume_pulse), 4'h0);

    // R2 rising edge, default config
    ext_en = 1'b1;
    ext_pin = 1'b1;
    tick(2);
    chk("R2 not yet", 4'(ext_pend), 4'h0);
    tick(1);
    chk("R2 edge sets", 4'(ext_pend), 4'h1);
    chk("R7 ext request", 4'({irq_req, irq_is_nmi}), 4'h2);
    pulse_ack(1'b0);
    chk("R2 ack clears", 4'(ext_pend), 4'h0);
    tick(3);
    chk("R2 held pin no retrigger", 4'(ext_pend), 4'h0);
    ext_pin = 1'b0;
    tick(4);
    chk("R2 falling ignored", 4'(ext_pend), 4'h0);

    // R4/R5 falling edge sense
    set_cfg(1'b0, 1'b0);
    tick(4);
    chk("R5 steady low no false trigger", 4'(ext_pend), 4'h0);
    ext_pin = 1'b1;
    tick(4);
    chk("R4 rising ignored", 4'(ext_pend), 4'h0);
    ext_pin = 1'b0;
    tick(3);
    chk("R4 falling sets", 4'(ext_pend), 4'h1);

    // R5 clear on config write, R3 level high
    set_cfg(1'b1, 1'b1);
    chk("R5 cfg clears", 4'(ext_pend), 4'h0);
    tick(3);
    chk("R3 low inactive", 4'(ext_pend), 4'h0);
    ext_pin = 1'b1;
    tick(2);
    chk("R3 not yet", 4'(ext_pend), 4'h0);
    tick(1);
    chk("R3 level follows", 4'(ext_pend), 4'h1);
    pulse_ack(1'b0);
    chk("R3 ack ignored", 4'(ext_pend), 4'h1);
    ext_pin = 1'b0;
    tick(3);
    chk("R3 level drops", 4'(ext_pend), 4'h0);

    // R4 level low sense
    set_cfg(1'b1, 1'b0);
    chk("R5 cfg cycle clear", 4'(ext_pend), 4'h0);
    tick(1);
    chk("R4 low level active", 4'(ext_pend), 4'h1);
    ext_pin = 1'b1;
    tick(3);
    chk("R4 high inactive", 4'(ext_pend), 4'h0);
    set_cfg(1'b0, 1'b1);
    tick(4);
    chk("R5 held high no edge after change", 4'(ext_pend), 4'h0);
    ext_pin = 1'b0;
    tick(4);

    // R6 NMI filter
    nmi_pin = 1'b1;
    tick(1);
    nmi_pin = 1'b0;
    tick(5);
    chk("R6 short pulse ignored", 4'(nmi_pend), 4'h0);

    // R7 collision: both pins rise together
    ext_pin = 1'b1;
    nmi_pin = 1'b1;
    tick(3);
    chk("R7 ext first", 4'({ext_pend, nmi_pend, irq_is_nmi}), 4'h4);
    tick(1);
    chk("R6 nmi after fourth edge", 4'(nmi_pend), 4'h1);
    chk("R7 nmi wins", 4'({irq_req, irq_is_nmi}), 4'h3);
    pulse_ack(1'b1);
    chk("R6 ack_nmi clears", 4'(nmi_pend), 4'h0);
    chk("R7 ext after nmi", 4'({irq_req, irq_is_nmi}), 4'h2);
    pulse_ack(1'b0);
    tick(3);
    chk("R6 held nmi no retrigger", 4'(nmi_pend), 4'h0);
    ext_pin = 1'b0;
    nmi_pin = 1'b0;
    tick(4);

    // R8 mode commands
    send_mode(2'd3);
    chk("R8 code 3 ignored", 4'(pm_state), 4'h0);
    ext_en = 1'b0;
    send_mode(2'd1);
    chk("R8 enter idle", 4'(pm_state), 4'h1);
    ext_pin = 1'b1;
    tick(5);
    chk("R9 disabled ext keeps idle", 4'({ext_pend, pm_state}), 4'h5);
    chk("R7 no req in idle", 4'(irq_req), 4'h0);
    send_mode(2'd2);
    chk("R8 cmd ignored in idle", 4'(pm_state), 4'h1);
    exp_q.push_back(1'b1);
    ext_en = 1'b1;
    tick(1);
    chk("R9 idle wake", 4'({pm_state, resume_pulse, resume_vector}), 4'h3);
    tick(1);
    chk("R11 one cycle", 4'(resume_pulse), 4'h0);
    chk("R7 req after wake", 4'(irq_req), 4'h1);
    pulse_ack(1'b0);
    ext_pin = 1'b0;
    tick(4);

    // R9 NMI ends idle
    send_mode(2'd1);
    exp_q.push_back(1'b1);
    nmi_pin = 1'b1;
    tick(2);
    nmi_pin = 1'b0;
    tick(2);
    chk("R9 nmi pending still idle", 4'({nmi_pend, pm_state}), 4'h5);
    tick(1);
    chk("R9 nmi wake", 4'({pm_state, resume_pulse}), 4'h1);
    pulse_ack(1'b1);

    // R10 powerdown, ext disabled, NMI ignored
    ext_en = 1'b0;
    send_mode(2'd2);
    chk("R8 enter powerdown", 4'(pm_state), 4'h2);
    nmi_pin = 1'b1;
    tick(6);
    chk("R10 nmi ignored", 4'({nmi_pend, pm_state}), 4'h2);
    nmi_pin = 1'b0;
    exp_q.push_back(1'b0);
    ext_pin = 1'b1;
    tick(2);
    chk("R10 still asleep", 4'(pm_state), 4'h2);
    tick(1);
    chk("R10 wake continue", 4'({pm_state, resume_pulse, resume_vector}), 4'h2);
    tick(3);
    chk("R10 no pend when disabled", 4'({ext_pend, nmi_pend}), 4'h0);
    ext_pin = 1'b0;
    tick(4);

    // R10 powerdown, ext enabled, short pulse
    ext_en = 1'b1;
    send_mode(2'd2);
    exp_q.push_back(1'b1);
    ext_pin = 1'b1;
    #(CLK_PERIOD/4);
    ext_pin = 1'b0;
    tick(3);
    chk("R10 wake vector", 4'({pm_state, resume_pulse, resume_vector}), 4'h3);
    chk("R10 pend set on wake", 4'(ext_pend), 4'h1);
    pulse_ack(1'b0);
    tick(2);

    chk("R11 all resumes seen", 4'(exp_q.size()), 4'h0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule